// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout Actions

This peripheral guards a processor against a stalled program. Software programs one 8-bit control/status byte that picks a timeout length and an action. Once armed, the block counts strobes from an external tick input. If software neither kicks it (a one-cycle pulse from the CPU's watchdog-restart instruction) nor rewrites the byte before the count reaches the programmed length, the block raises an interrupt, asks for a system reset, or does both in turn.

The timeout is a base period of `BASE_TICKS` ticks multiplied by a power of two. The exponent is a 4-bit field whose upper bit is stored apart from the three lower bits. The two enable bits give four modes. When both are clear the block is stopped. With the interrupt enable alone, a timeout sets the pending flag. With the reset enable alone, a timeout issues a reset request. With both set, the first timeout sets the flag and clears the interrupt enable in hardware, so the second timeout requests a reset. After every timeout the count starts again from zero and runs another full period.

Top module: `wdog_top`

## Requirements
- R1: While reset is applied, and after it is released, the register reads 0x00, `irq_o` is low and `sys_rst_req_o` is low.
- R2: Bit map of the register: bits 2:0 hold exponent bits 2:0, bit 3 is the reset enable, bit 4 is a stored change-enable bit, bit 5 holds exponent bit 3, bit 6 is the interrupt enable and bit 7 is the pending flag. A write stores bits 6:0 as written, and `bus_rdata` always shows the whole register.
- R3: Let the exponent p be {bit5, bit2, bit1, bit0}. A timeout occurs on exactly the (BASE_TICKS << p)-th tick strobe after the count restarts. Values of p above 9 behave as 9.
- R4: When bits 3 and 6 are both 0, no number of ticks produces an interrupt or a reset request.
- R5: With bit 6 set and bit 3 clear, a timeout sets bit 7, which drives `irq_o` high. No reset request is issued.
- R6: With bit 3 set and bit 6 clear, a timeout produces a `sys_rst_req_o` pulse exactly one cycle long and leaves bit 7 unchanged. The count then starts again, and the next pulse follows one full period later.
- R7: With bits 3 and 6 both set, a timeout sets bit 7 and clears bit 6 in the same cycle, with no reset request. The next full period then ends in a reset request.
- R8: A one-cycle pulse on `kick_i` restarts the count from zero, and no timeout occurs in that cycle.
- R9: Any register write restarts the count from zero.
- R10: Writing 1 to bit 7 clears the flag and drops `irq_o` in the next cycle. Writing 0 to bit 7 leaves the flag as it was.
- R11: `irq_o` is high exactly while bit 7 of the register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Byte write strobe for the control/status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current register contents |
| kick_i | input | 1 | Restart pulse from the CPU |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| irq_o | output | 1 | Interrupt request, level, follows the pending flag |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench probes the exponent boundaries: p of 0, of 8 (which needs the non-adjacent bit), of 9, and a value above 9 that must clamp. A design that assembled the exponent from adjacent bits, or did not clamp, would fire at the wrong tick count, and the check one tick before the expected timeout would catch it. Restart is exercised by a kick and by a write at three ticks into a four-tick period. A design that ignored either would fire one period early. The combined mode is run through both of its timeouts, which exposes a design that never cleared the interrupt enable or that issued a reset on the first timeout. Flag handling is checked for a write of 1 (the flag must clear) and a write of 0 (the flag must hold). The reset pulse is sampled in the cycle after it appears, where a level output would still be high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Register bit positions that other logic decodes
  localparam int BIT_P0   = 0;
  localparam int BIT_P1   = 1;
  localparam int BIT_P2   = 2;
  localparam int BIT_RSTE = 3;
  localparam int BIT_CHGE = 4;
  localparam int BIT_P3   = 5;
  localparam int BIT_IRQE = 6;
  localparam int BIT_FLAG = 7;

  // Mode encoded as {reset enable, interrupt enable}
  typedef enum logic [1:0] {
    WD_OFF  = 2'b00,
    WD_IRQ  = 2'b01,
    WD_RST  = 2'b10,
    WD_BOTH = 2'b11
  } wd_mode_e;

  typedef struct packed {
    logic [3:0] scale;
    wd_mode_e   mode;
  } wd_cfg_t;

  function automatic logic [3:0] pick_scale(input logic [7:0] r);
    return {r[BIT_P3], r[BIT_P2], r[BIT_P1], r[BIT_P0]};
  endfunction

  function automatic wd_mode_e pick_mode(input logic [7:0] r);
    return wd_mode_e'({r[BIT_RSTE], r[BIT_IRQE]});
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/wdog_csr.sv
module wdog_csr
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       set_flag,
  input  logic       drop_irqe,
  output logic [7:0] csr_o,
  output wd_cfg_t    cfg_o
);

  logic [7:0] csr_q;
  logic [7:0] csr_d;
  logic       csr_en;

  always_comb begin
    csr_d  = csr_q;
    csr_en = 1'b0;
    if (wr_en) begin
      csr_en          = 1'b1;
      csr_d           = wr_data;
      // flag: write-one-to-clear, write-zero keeps
      csr_d[BIT_FLAG] = wr_data[BIT_FLAG] ? 1'b0 : csr_q[BIT_FLAG];
    end else if (set_flag || drop_irqe) begin
      csr_en = 1'b1;
      if (set_flag)  csr_d[BIT_FLAG] = 1'b1;
      if (drop_irqe) csr_d[BIT_IRQE] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= 8'h00;
    end else if (csr_en) begin
      csr_q <= csr_d;
    end
  end

  assign csr_o       = csr_q;
  assign cfg_o.scale = pick_scale(csr_q);
  assign cfg_o.mode  = pick_mode(csr_q);

endmodule

// File: rtl/wdog_period.sv
module wdog_period #(
  parameter int BASE_TICKS = 16,
  parameter int MAX_SCALE  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       restart,
  input  logic       tick,
  input  logic [3:0] scale,
  output logic       expire_o
);

  localparam int CNT_W = $clog2(BASE_TICKS) + MAX_SCALE + 1;

  logic [CNT_W-1:0] lim_tbl [MAX_SCALE+1];
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [3:0]       scale_c;
  logic             at_end;

  // Last count value for every legal exponent
  genvar g;
  generate
    for (g = 0; g <= MAX_SCALE; g++) begin : g_lim
      assign lim_tbl[g] = CNT_W'((BASE_TICKS << g) - 1);
    end
  endgenerate

  assign scale_c = (scale > 4'(MAX_SCALE)) ? 4'(MAX_SCALE) : scale;

  always_comb begin
    lim = '0;
    for (int s = 0; s <= MAX_SCALE; s++) begin
      if (scale_c == 4'(s)) lim = lim_tbl[s];
    end
  end

  assign at_end   = (cnt_q >= lim);
  assign expire_o = armed && !restart && tick && at_end;

  always_comb begin
    cnt_en = restart || !armed || tick;
    if (restart || !armed) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     expire,
  input  wd_mode_e mode,
  output logic     set_flag,
  output logic     drop_irqe,
  output logic     rst_req_o
);

  logic fire_rst;
  logic req_q;
  logic req_d;

  always_comb begin
    set_flag  = 1'b0;
    drop_irqe = 1'b0;
    fire_rst  = 1'b0;
    unique case (mode)
      WD_IRQ:  set_flag = expire;
      WD_RST:  fire_rst = expire;
      WD_BOTH: begin
        set_flag  = expire;
        drop_irqe = expire;
      end
      default: ;
    endcase
  end

  // Request never lasts longer than one cycle
  assign req_d = fire_rst && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign rst_req_o = req_q;

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int MAX_SCALE  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       kick_i,
  input  logic       tick_i,
  output logic       irq_o,
  output logic       sys_rst_req_o
);

  logic       rst_n_int;
  logic [7:0] csr;
  wd_cfg_t    cfg;
  logic       expire;
  logic       set_flag;
  logic       drop_irqe;
  logic       restart;
  logic       armed;

  wdog_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  wdog_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (bus_wr),
    .wr_data   (bus_wdata),
    .set_flag  (set_flag),
    .drop_irqe (drop_irqe),
    .csr_o     (csr),
    .cfg_o     (cfg)
  );

  assign restart = bus_wr || kick_i;
  assign armed   = (cfg.mode != WD_OFF);

  wdog_period #(
    .BASE_TICKS (BASE_TICKS),
    .MAX_SCALE  (MAX_SCALE)
  ) u_period (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .armed    (armed),
    .restart  (restart),
    .tick     (tick_i),
    .scale    (cfg.scale),
    .expire_o (expire)
  );

  wdog_action u_action (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .expire    (expire),
    .mode      (cfg.mode),
    .set_flag  (set_flag),
    .drop_irqe (drop_irqe),
    .rst_req_o (sys_rst_req_o)
  );

  assign bus_rdata = csr;
  assign irq_o     = csr[BIT_FLAG];

endmodule

// File: rtl/wdog_top_chk.sv
module wdog_top_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_wr,
  input logic wr_clr,
  input logic kick_i,
  input logic rd_flag,
  input logic rd_irqe,
  input logic rd_rste,
  input logic irq_o,
  input logic sys_rst_req_o
);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |=> !sys_rst_req_o); // R6

  AST_RST_ONLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |-> $past(rd_rste && !rd_irqe)); // R6

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_rste && !rd_irqe) |-> (!sys_rst_req_o && !$rose(irq_o))); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(rd_irqe)); // R5

  AST_BOTH_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && $past(rd_rste)) |-> !rd_irqe); // R7

  AST_KICK_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kick_i || bus_wr) |-> (!sys_rst_req_o && !$rose(irq_o))); // R8

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && wr_clr) |-> !irq_o); // R10

  AST_IRQ_IS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == rd_flag); // R11

endmodule

bind wdog_top wdog_top_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .wr_clr        (bus_wdata[7]),
  .kick_i        (kick_i),
  .rd_flag       (bus_rdata[7]),
  .rd_irqe       (bus_rdata[6]),
  .rd_rste       (bus_rdata[3]),
  .irq_o         (irq_o),
  .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/wdog_top_tb.sv
`timescale 1ns/1ps
module wdog_top_tb;

  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       kick_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       irq_o;
  logic       sys_rst_req_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_top #(.BASE_TICKS(BASE), .MAX_SCALE(9)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .kick_i        (kick_i),
    .tick_i        (tick_i),
    .irq_o         (irq_o),
    .sys_rst_req_o (sys_rst_req_o)
  );

  // {scale[3:0], reset enable, interrupt enable}
  localparam logic [5:0] VEC [8] = '{
    {4'd0,  1'b0, 1'b1},
    {4'd1,  1'b1, 1'b0},
    {4'd3,  1'b0, 1'b1},
    {4'd8,  1'b1, 1'b0},
    {4'd9,  1'b0, 1'b1},
    {4'd12, 1'b1, 1'b0},
    {4'd2,  1'b1, 1'b1},
    {4'd5,  1'b1, 1'b0}
  };

  function automatic logic [7:0] mk(input int sc, input bit re, input bit ie, input bit clr);
    logic [7:0] r;
    logic [3:0] s;
    s    = 4'(sc);
    r    = 8'h00;
    r[2:0] = s[2:0];
    r[5] = s[3];
    r[3] = re;
    r[6] = ie;
    r[7] = clr;
    return r;
  endfunction

  function automatic int tlim(input int sc);
    return BASE << ((sc > 9) ? 9 : sc);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = 8'h00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic kick();
    @(negedge clk);
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    logic [7:0] v;
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", 32'(bus_rdata), 32'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rdata", 32'(bus_rdata), 32'h00);
    check("R1 irq", 32'(irq_o), 32'd0);
    check("R1 rstreq", 32'(sys_rst_req_o), 32'd0);

    // R2: readback of stored bits, flag not writable to 1
    wr(8'h37);
    check("R2 readback 0x37", 32'(bus_rdata), 32'h37);
    wr(8'hC8);
    check("R2 readback flag stays clear", 32'(bus_rdata), 32'h48);
    wr(8'h00);

    // R3 R5 R6 R7: table of exponent/mode vectors
    for (int k = 0; k < 8; k++) begin
      v = 8'(VEC[k]);
      wr(mk(int'(v[5:2]), v[1], v[0], 1'b1));
      ticks(tlim(int'(v[5:2])) - 1);
      check("R3 early irq", 32'(irq_o), 32'd0);
      check("R3 early rstreq", 32'(sys_rst_req_o), 32'd0);
      ticks(1);
      check("R3 R5 R7 irq at timeout", 32'(irq_o), 32'(v[0]));
      check("R3 R6 rstreq at timeout", 32'(sys_rst_req_o), 32'(v[1] & ~v[0]));
    end

    // R4: stopped mode with largest exponent
    wr(8'hA7);
    ticks(2100);
    check("R4 stopped irq", 32'(irq_o), 32'd0);
    check("R4 stopped rstreq", 32'(sys_rst_req_o), 32'd0);

    // R6: pulse width, flag untouched, re-arm
    wr(mk(1, 1'b1, 1'b0, 1'b1));
    ticks(8);
    check("R6 pulse", 32'(sys_rst_req_o), 32'd1);
    check("R6 flag untouched", 32'(bus_rdata[7]), 32'd0);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(sys_rst_req_o), 32'd0);
    ticks(7);
    check("R6 re-arm early", 32'(sys_rst_req_o), 32'd0);
    ticks(1);
    check("R6 re-arm pulse", 32'(sys_rst_req_o), 32'd1);

    // R5 R10 R11: flag set, write-0 keeps, write-1 clears
    wr(mk(0, 1'b0, 1'b1, 1'b1));
    ticks(4);
    check("R5 irq", 32'(irq_o), 32'd1);
    check("R11 flag bit", 32'(bus_rdata[7]), 32'd1);
    check("R5 no rstreq", 32'(sys_rst_req_o), 32'd0);
    wr(mk(0, 1'b0, 1'b1, 1'b0));
    check("R10 write0 keeps", 32'(irq_o), 32'd1);
    wr(mk(0, 1'b0, 1'b1, 1'b1));
    check("R10 write1 clears irq", 32'(irq_o), 32'd0);
    check("R10 write1 clears flag", 32'(bus_rdata[7]), 32'd0);

    // R8: kick restarts
    wr(mk(0, 1'b0, 1'b1, 1'b1));
    ticks(3);
    kick();
    ticks(3);
    check("R8 kick delays", 32'(irq_o), 32'd0);
    ticks(1);
    check("R8 timeout after kick", 32'(irq_o), 32'd1);

    // R9: write restarts
    wr(mk(0, 1'b0, 1'b1, 1'b1));
    ticks(3);
    wr(mk(0, 1'b0, 1'b1, 1'b0));
    ticks(3);
    check("R9 write delays", 32'(irq_o), 32'd0);
    ticks(1);
    check("R9 timeout after write", 32'(irq_o), 32'd1);

    // R7: combined mode, two stages
    wr(mk(1, 1'b1, 1'b1, 1'b1));
    ticks(8);
    check("R7 irq first", 32'(irq_o), 32'd1);
    check("R7 no rstreq first", 32'(sys_rst_req_o), 32'd0);
    check("R7 irq enable dropped", 32'(bus_rdata[6]), 32'd0);
    ticks(7);
    check("R7 second early", 32'(sys_rst_req_o), 32'd0);
    ticks(1);
    check("R7 second rstreq", 32'(sys_rst_req_o), 32'd1);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async rdata", 32'(bus_rdata), 32'h00);
    check("R1 async irq", 32'(irq_o), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 32'(bus_rdata), 32'h00);

    finish_run();
  end

endmodule